// File: doc/BRIEF.md
# Latency-Table Stall Interlock

This block decides, cycle by cycle, whether the instruction that decode presents may enter execution in a single-issue pipeline. It keeps a short record of the most recent issued producers: each entry holds the destination register, the operation class and the entry's age. The block compares the candidate's enabled source registers with the enabled destinations in that record. The number of stall cycles comes from a producer/consumer latency table. When the table demands more distance than has passed, the block raises a stall that holds decode and sends a bubble into execution. Each cycle, including each bubble, ages the record by one.

The block also manages a single delayed-branch slot. The instruction that follows an issued branch always executes and is flagged as the slot occupant. If decode has nothing to offer in that cycle, the slot becomes a bubble. Forwarding, the datapath and prediction lie outside the block. The latency table already assumes the forwarding paths that exist.

Top module: `ilk_interlock`

## Requirements
- R1: Class codes on `in_class_i` are 0 integer, 1 FP ALU, 2 load double, 3 store double, 4 branch. An FP ALU result read by a later FP ALU op needs 3 stall cycles between them (parameter `LAT_FP_FP`).
- R2: An FP ALU result read by a store double needs 2 stall cycles (`LAT_FP_ST`).
- R3: A load double result read by an FP ALU op needs 1 stall cycle (`LAT_LD_FP`).
- R4: Every other class pair needs no stall, among them load to store, integer to integer, integer to store and integer to branch.
- R5: A dependence exists only between an enabled source and an enabled destination with equal register numbers. A disabled source or a disabled destination is ignored.
- R6: With several conflicting producers, the stall lasts the largest single requirement. `wait_o` shows the remaining stall cycles of the presented instruction and falls by one each stalled cycle while decode holds its inputs.
- R7: `stall_o` and `issue_o` are never high together. `bubble_o` is high in every cycle without an issue, and stall cycles also age the producer record.
- R8: The cycle after a branch issues is its delay slot. `slot_o` stays high until an instruction issues or the input is empty. A slot instruction that must stall keeps the slot.
- R9: An empty delay slot produces a bubble with `slot_o` high and no stall.
- R10: Asynchronous reset empties the producer record and clears any pending slot. `stall_o`, `issue_o`, `slot_o` and `wait_o` are all 0 when no instruction is offered.
- R11: The unscheduled vector loop (load, add, store, decrement, branch, empty slot) takes 9 cycles per iteration. With the store moved into the slot it takes 6 cycles. The four-way unrolled, scheduled body takes 14 cycles with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decode offers an instruction |
| in_class_i | input | 3 | Operation class of the offered instruction |
| in_src_a_i | input | REG_W | First source register |
| in_src_a_en_i | input | 1 | First source is read |
| in_src_b_i | input | REG_W | Second source register |
| in_src_b_en_i | input | 1 | Second source is read |
| in_dst_i | input | REG_W | Destination register |
| in_dst_en_i | input | 1 | Destination is written |
| stall_o | output | 1 | Hold decode; a bubble enters execution |
| issue_o | output | 1 | Offered instruction enters execution this cycle |
| bubble_o | output | 1 | Execution receives no instruction this cycle |
| slot_o | output | 1 | This cycle is a branch delay slot |
| wait_o | output | CNT_W | Remaining stall cycles for the offered instruction |

## Verification
The bench replays the three loop schedules and checks the issue, stall or bubble outcome and the remaining count in every cycle. An off-by-one in the age comparison shows up as a shifted or missing bubble in these loops. It also sets up two producers with overlapping windows. A design that took the first match, and not the largest requirement, would release the consumer one cycle early there. Further cases cover a stalled instruction in a delay slot, which must keep its slot flag, an empty slot, which must not count as a stall, and disabled sources or destinations, which must not create a dependence. A reset issued right after a producer and a branch checks that no stale entry or pending slot remains. A design that kept either would stall or flag the next instruction.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_INT    = 3'd0,
    CLS_FPALU  = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4
  } op_cls_e;

  // producer/consumer stall requirement
  function automatic int lat_of(input op_cls_e prod, input op_cls_e cons,
                                input int fp_fp, input int fp_st, input int ld_fp);
    if (prod == CLS_FPALU && cons == CLS_FPALU) return fp_fp;
    if (prod == CLS_FPALU && cons == CLS_STORE) return fp_st;
    if (prod == CLS_LOAD  && cons == CLS_FPALU) return ld_fp;
    return 0;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ilk_track.sv
module ilk_track #(
  parameter int DEPTH = 3,
  parameter int REG_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [REG_W-1:0]            push_dst_i,
  input  logic [2:0]                  push_cls_i,
  output logic [DEPTH-1:0]            ent_vld_o,
  output logic [DEPTH-1:0][REG_W-1:0] ent_dst_o,
  output logic [DEPTH-1:0][2:0]       ent_cls_o
);

  // entry 0 is one cycle old, entry DEPTH-1 is DEPTH cycles old
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_o <= '0;
      ent_dst_o <= '0;
      ent_cls_o <= '0;
    end else begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        ent_vld_o[i] <= ent_vld_o[i-1];
        ent_dst_o[i] <= ent_dst_o[i-1];
        ent_cls_o[i] <= ent_cls_o[i-1];
      end
      ent_vld_o[0] <= push_i;
      ent_dst_o[0] <= push_dst_i;
      ent_cls_o[0] <= push_cls_i;
    end
  end

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int REG_W     = 6,
  parameter int LAT_FP_FP = 3,
  parameter int LAT_FP_ST = 2,
  parameter int LAT_LD_FP = 1,
  parameter int CNT_W     = 2
) (
  input  logic [2:0]                  cons_cls_i,
  input  logic [REG_W-1:0]            src_a_i,
  input  logic                        src_a_en_i,
  input  logic [REG_W-1:0]            src_b_i,
  input  logic                        src_b_en_i,
  input  logic [DEPTH-1:0]            ent_vld_i,
  input  logic [DEPTH-1:0][REG_W-1:0] ent_dst_i,
  input  logic [DEPTH-1:0][2:0]       ent_cls_i,
  output logic [CNT_W-1:0]            wait_o
);

  logic [CNT_W-1:0] ent_wait [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    int   need;
    assign hit  = ent_vld_i[i] &&
                  ((src_a_en_i && src_a_i == ent_dst_i[i]) ||
                   (src_b_en_i && src_b_i == ent_dst_i[i]));
    assign need = lat_of(op_cls_e'(ent_cls_i[i]), op_cls_e'(cons_cls_i),
                         LAT_FP_FP, LAT_FP_ST, LAT_LD_FP);
    // age is i+1; cycles still owed = need - age + 1
    assign ent_wait[i] = (hit && need > i) ? CNT_W'(need - i) : '0;
  end

  always_comb begin
    wait_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_wait[i] > wait_o) wait_o = ent_wait[i];
    end
  end

endmodule

// File: rtl/ilk_slot.sv
module ilk_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic issue_i,
  input  logic is_branch_i,
  output logic slot_o
);

  logic slot_q, slot_d;

  always_comb begin
    slot_d = slot_q;
    if (slot_q && (issue_i || !in_valid_i)) slot_d = 1'b0;
    if (issue_i && is_branch_i)             slot_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= 1'b0;
    else         slot_q <= slot_d;
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int  REG_W     = 6,
  parameter int  LAT_FP_FP = 3,
  parameter int  LAT_FP_ST = 2,
  parameter int  LAT_LD_FP = 1,
  localparam int MAX_LAT   = max3(LAT_FP_FP, LAT_FP_ST, LAT_LD_FP),
  localparam int CNT_W     = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [2:0]       in_class_i,
  input  logic [REG_W-1:0] in_src_a_i,
  input  logic             in_src_a_en_i,
  input  logic [REG_W-1:0] in_src_b_i,
  input  logic             in_src_b_en_i,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic             in_dst_en_i,
  output logic             stall_o,
  output logic             issue_o,
  output logic             bubble_o,
  output logic             slot_o,
  output logic [CNT_W-1:0] wait_o
);

  localparam int DEPTH = (MAX_LAT < 1) ? 1 : MAX_LAT;

  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0][REG_W-1:0] ent_dst;
  logic [DEPTH-1:0][2:0]       ent_cls;
  logic [CNT_W-1:0]            wait_raw;

  ilk_track #(.DEPTH(DEPTH), .REG_W(REG_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (issue_o && in_dst_en_i),
    .push_dst_i (in_dst_i),
    .push_cls_i (in_class_i),
    .ent_vld_o  (ent_vld),
    .ent_dst_o  (ent_dst),
    .ent_cls_o  (ent_cls)
  );

  ilk_hazard #(
    .DEPTH(DEPTH), .REG_W(REG_W), .LAT_FP_FP(LAT_FP_FP),
    .LAT_FP_ST(LAT_FP_ST), .LAT_LD_FP(LAT_LD_FP), .CNT_W(CNT_W)
  ) u_hazard (
    .cons_cls_i (in_class_i),
    .src_a_i    (in_src_a_i),
    .src_a_en_i (in_src_a_en_i),
    .src_b_i    (in_src_b_i),
    .src_b_en_i (in_src_b_en_i),
    .ent_vld_i  (ent_vld),
    .ent_dst_i  (ent_dst),
    .ent_cls_i  (ent_cls),
    .wait_o     (wait_raw)
  );

  assign wait_o   = in_valid_i ? wait_raw : '0;
  assign stall_o  = in_valid_i && (wait_raw != '0);
  assign issue_o  = in_valid_i && !stall_o;
  assign bubble_o = !issue_o;

  ilk_slot u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .issue_i     (issue_o),
    .is_branch_i (in_class_i == CLS_BRANCH),
    .slot_o      (slot_o)
  );

endmodule

// File: rtl/ilk_interlock_chk.sv
module ilk_interlock_chk #(
  parameter int REG_W     = 6,
  parameter int LAT_FP_FP = 3,
  parameter int CNT_W     = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [2:0]       in_class_i,
  input logic [REG_W-1:0] in_src_a_i,
  input logic             in_src_a_en_i,
  input logic [REG_W-1:0] in_src_b_i,
  input logic             in_src_b_en_i,
  input logic [REG_W-1:0] in_dst_i,
  input logic             in_dst_en_i,
  input logic             stall_o,
  input logic             issue_o,
  input logic             bubble_o,
  input logic             slot_o,
  input logic [CNT_W-1:0] wait_o
);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r7_stall_is_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (bubble_o && !issue_o));

  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (stall_o && wait_o > 1) |=> (stall_o && wait_o == $past(wait_o) - 1'b1));

  a_r1_fp_fp_src_a: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (LAT_FP_FP > 0 && $past(issue_o && in_class_i == 3'd1 && in_dst_en_i) &&
     in_valid_i && in_class_i == 3'd1 && in_src_a_en_i && in_src_a_i == $past(in_dst_i))
    |-> (stall_o && wait_o == CNT_W'(LAT_FP_FP)));

  a_r1_fp_fp_src_b: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (LAT_FP_FP > 0 && $past(issue_o && in_class_i == 3'd1 && in_dst_en_i) &&
     in_valid_i && in_class_i == 3'd1 && in_src_b_en_i && in_src_b_i == $past(in_dst_i))
    |-> stall_o);

  a_r8_slot_follows_branch: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(issue_o && in_class_i == 3'd4) |-> slot_o);

  a_r9_empty_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && !in_valid_i) |-> (bubble_o && !stall_o));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stall_o, issue_o}));

endmodule

bind ilk_interlock ilk_interlock_chk #(
  .REG_W(REG_W), .LAT_FP_FP(LAT_FP_FP), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/ilk_interlock_test.sv
module ilk_interlock_test;
  import ilk_pkg::*;

  typedef struct {
    bit      valid;
    op_cls_e cls;
    int      d;  bit de;
    int      a;  bit ae;
    int      b;  bit be;
  } instr_t;

  logic       clk_i = 0, rst_ni = 0;
  logic       in_valid_i = 0;
  logic [2:0] in_class_i = 0;
  logic [5:0] in_src_a_i = 0, in_src_b_i = 0, in_dst_i = 0;
  logic       in_src_a_en_i = 0, in_src_b_en_i = 0, in_dst_en_i = 0;
  logic       stall_o, issue_o, bubble_o, slot_o;
  logic [1:0] wait_o;

  ilk_interlock uut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int     nchk = 0, nfail = 0;
  instr_t prog[$];
  byte    expq[$];
  bit     active = 0;
  string  tag;
  int     cyc;

  function automatic int R(int n); return n; endfunction
  function automatic int F(int n); return 32 + n; endfunction

  function automatic instr_t mk(op_cls_e c, int d, bit de, int a, bit ae, int b, bit be);
    instr_t x;
    x.valid = 1; x.cls = c; x.d = d; x.de = de; x.a = a; x.ae = ae; x.b = b; x.be = be;
    return x;
  endfunction

  function automatic instr_t gap();
    instr_t x;
    x = mk(CLS_INT, 0, 0, 0, 0, 0, 0);
    x.valid = 0;
    return x;
  endfunction

  task automatic check(bit ok, string what, string got, string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %s expected %s", tag, what, got, exp);
    end
  endtask

  // driver: apply head of program after each rising edge
  always begin
    @(posedge clk_i); #1;
    if (active && prog.size() > 0) begin
      in_valid_i    = prog[0].valid;
      in_class_i    = prog[0].cls;
      in_dst_i      = 6'(prog[0].d);  in_dst_en_i   = prog[0].de;
      in_src_a_i    = 6'(prog[0].a);  in_src_a_en_i = prog[0].ae;
      in_src_b_i    = 6'(prog[0].b);  in_src_b_en_i = prog[0].be;
    end else begin
      in_valid_i = 0; in_src_a_en_i = 0; in_src_b_en_i = 0; in_dst_en_i = 0;
    end
  end

  always begin
    @(negedge clk_i);
    if (active && prog.size() > 0)
      if (!prog[0].valid || issue_o) void'(prog.pop_front());
  end

  // monitor: pop expected outcome per cycle and compare
  // codes: I issue, S issue in slot, E empty slot, G idle,
  //        1..3 stall with wait n, a..c stall inside slot with wait n-'a'+1
  always begin
    @(negedge clk_i);
    if (active && expq.size() > 0) begin
      byte c;
      bit ei, es, est;
      int ew;
      c = expq.pop_front();
      ei = 0; es = 0; est = 0; ew = 0;
      case (c)
        "I": ei = 1;
        "S": begin ei = 1; es = 1; end
        "E": es = 1;
        "1", "2", "3": begin est = 1; ew = c - "0"; end
        "a", "b", "c": begin est = 1; es = 1; ew = c - "a" + 1; end
        default: ;
      endcase
      check(issue_o == ei && slot_o == es && stall_o == est &&
            bubble_o == !ei && int'(wait_o) == ew,
            $sformatf("cycle %0d issue/slot/stall/bubble/wait", cyc),
            $sformatf("%b%b%b%b/%0d", issue_o, slot_o, stall_o, bubble_o, wait_o),
            $sformatf("%b%b%b%b/%0d", ei, es, est, !ei, ew));
      cyc++;
    end
  end

  task automatic run(string t, instr_t p[$], string exp);
    tag = t;
    prog = p;
    for (int i = 0; i < exp.len(); i++) expq.push_back(exp[i]);
    cyc = 1;
    active = 1;
    while (expq.size() != 0) @(negedge clk_i);
    #2;
    active = 0;
    check(prog.size() == 0, $sformatf("program done in %0d cycles", exp.len()),
          $sformatf("%0d left", prog.size()), "0 left");
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
    #2;
  endtask

  task automatic check_quiet(string t);
    tag = t;
    check(!stall_o && !issue_o && !slot_o && wait_o == 0, "outputs with no input",
          $sformatf("%b%b%b/%0d", stall_o, issue_o, slot_o, wait_o), "000/0");
  endtask

  instr_t ld, addd, sd, subi, bnez, sd_slot;
  instr_t body[$];

  initial begin
    ld   = mk(CLS_LOAD,   F(0), 1, R(1), 1, 0,    0);
    addd = mk(CLS_FPALU,  F(4), 1, F(0), 1, F(2), 1);
    sd   = mk(CLS_STORE,  0,    0, R(1), 1, F(4), 1);
    subi = mk(CLS_INT,    R(1), 1, R(1), 1, 0,    0);
    bnez = mk(CLS_BRANCH, 0,    0, R(1), 1, 0,    0);

    @(negedge clk_i); #2;
    check_quiet("R10 during reset");
    idle(2);
    rst_ni = 1;
    idle(1);
    check_quiet("R10 after reset");

    // R11 / R3 / R2 / R4 / R9: unscheduled loop, two iterations
    run("R11 unscheduled loop x2",
        {ld, addd, sd, subi, bnez, gap(), ld, addd, sd, subi, bnez, gap()},
        "I1I21IIIEI1I21IIIE");
    idle(4);

    // R11 / R8: store moved into the slot
    run("R11 scheduled loop", {ld, addd, subi, bnez, sd}, "I1IIIS");
    idle(4);

    // R11: unrolled four times and scheduled
    body = {};
    for (int k = 0; k < 4; k++) body.push_back(mk(CLS_LOAD, F(4*k+0) == F(0) ? F(0) : F(6+4*(k-1)), 1, R(1), 1, 0, 0));
    for (int k = 0; k < 4; k++) body.push_back(mk(CLS_FPALU, (k == 0) ? F(4) : F(8+4*(k-1)), 1,
                                                 (k == 0) ? F(0) : F(6+4*(k-1)), 1, F(2), 1));
    for (int k = 0; k < 3; k++) body.push_back(mk(CLS_STORE, 0, 0, R(1), 1, (k == 0) ? F(4) : F(8+4*(k-1)), 1));
    body.push_back(subi);
    body.push_back(bnez);
    body.push_back(mk(CLS_STORE, 0, 0, R(1), 1, F(16), 1));
    run("R11 unrolled loop", body, "IIIIIIIIIIIIIS");
    idle(4);

    run("R1 fp to fp",
        {addd, mk(CLS_FPALU, F(6), 1, F(8), 1, F(4), 1)}, "I321I");
    idle(4);

    run("R6 max of producers",
        {addd, mk(CLS_LOAD, F(6), 1, R(2), 1, 0, 0), mk(CLS_FPALU, F(10), 1, F(4), 1, F(6), 1)},
        "II21I");
    idle(4);

    run("R4 load to store", {ld, mk(CLS_STORE, 0, 0, R(1), 1, F(0), 1)}, "II");
    idle(4);
    run("R4 int to int", {subi, mk(CLS_INT, R(2), 1, R(1), 1, 0, 0)}, "II");
    idle(4);

    run("R5 source disabled", {addd, mk(CLS_FPALU, F(6), 1, F(4), 0, F(8), 1)}, "II");
    idle(4);
    run("R5 register differs", {addd, mk(CLS_FPALU, F(6), 1, F(5), 1, F(8), 1)}, "II");
    idle(4);
    run("R5 destination disabled",
        {mk(CLS_FPALU, F(4), 0, F(0), 1, F(2), 1), mk(CLS_FPALU, F(6), 1, F(4), 1, 0, 0)}, "II");
    idle(4);

    sd_slot = mk(CLS_FPALU, F(6), 1, F(4), 1, 0, 0);
    run("R8 stalled slot keeps slot", {addd, bnez, sd_slot}, "IIbaS");
    idle(4);
    run("R9 empty slot", {bnez, gap(), subi}, "IEI");
    idle(4);

    // R10: reset right after producer and branch
    run("R10 before reset", {addd, bnez}, "II");
    rst_ni = 0;
    @(negedge clk_i); #2;
    check_quiet("R10 reset clears slot");
    rst_ni = 1;
    run("R10 record cleared", {sd_slot}, "I");
    idle(4);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog expired in %s", tag);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule